// File: doc/BRIEF.md
# Masked Lane Load Writeback Formatter

This block sits at the return side of a local-memory pipeline. For one wavefront it accepts a load response, a memory type code, a destination width, a register count, destination addressing and a per-lane execution mask. It then emits one vector-register write per cycle, covering all lanes at once. Each beat carries a register address, a per-lane write enable and the per-lane data widened to the destination width. Stores and atomics that return nothing are accepted and acknowledged, but they write no register data.

Both data paths are valid/ready. On the input side, `in_ready` is high only while no writeback is pending. A command moves on the cycle that `in_valid` and `in_ready` are both high. The block captures everything it needs on that edge, so the source may change its inputs right after. On the output side, a beat stays presented, unchanged, for as long as `wr_valid` is high and `wr_ready` is low. `done` is a plain one-cycle pulse that closes each command.

The lane count, the maximum register count, the contiguous-addressing limit and the register address width are parameters.

Top module: `lane_load_writeback`

## Requirements
- R1: `in_ready` is 1 exactly when no write beat is pending. A command is taken when `in_valid` and `in_ready` are both 1, and later changes on the command inputs do not affect beats already owed.
- R2: Operation codes are 0 = load and 1 = atomic with return, which both produce write beats, and 2 = store and 3 = atomic without return. For codes 2 and 3, `wr_valid` stays 0 and `done` pulses in the cycle after acceptance.
- R3: Beat k has address `in_base + k` when the count is at most DIRECT_MAX (default 2). Above that limit, beat k has address `in_list[k*REG_W +: REG_W]`.
- R4: On beat k, lane i carries element k*LANES+i. Element e is taken from `in_data[e*64 +: 64]`, and lane i is placed at `wr_data[i*64 +: 64]`.
- R5: On every beat, `wr_lane_en` equals the accepted execution mask.
- R6: Integer type codes are U8=0, U16=1, U32=2, U64=3, S8=4, S16=5, S32=6 and S64=7. Bits above the type's width are ignored. U types are zero-extended and S types sign-extended to the destination width, which is 64 bits when `in_dst64`=1 and 32 bits otherwise. With a 32-bit destination, bits 63:32 of each lane are 0.
- R7: With a 32-bit destination, the 64-bit codes U64, S64 and F64 deliver the low 32 bits of the element.
- R8: Float codes are F16=8, F32=9 and F64=10. Half to single and single to double are exact for zero, subnormals, infinities and NaN payloads. Half to a 64-bit destination passes through single. F32 into 32 bits and F64 into 64 bits pass unchanged. Codes 11 to 15 produce zero data.
- R9: Beats leave in order k=0..count-1, one per accepted handshake. The first beat is valid in the cycle after acceptance, and `done` pulses in the cycle after the last handshake.
- R10: While `wr_valid`=1 and `wr_ready`=0, `wr_addr`, `wr_lane_en` and `wr_data` hold their values.
- R11: After reset, `in_ready`=1, `wr_valid`=0 and `done`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Command offered |
| in_ready | output | 1 | Command can be taken |
| in_op | input | 2 | Operation code |
| in_mtype | input | 4 | Memory element type code |
| in_dst64 | input | 1 | 1 selects a 64-bit destination width |
| in_count | input | CNT_W | Number of registers to write |
| in_base | input | REG_W | First register for contiguous addressing |
| in_list | input | MAX_REGS*REG_W | Destination register list |
| in_mask | input | LANES | Per-lane execution mask |
| in_data | input | LANES*MAX_REGS*64 | Packed returned elements, 64 bits each |
| wr_valid | output | 1 | Write beat presented |
| wr_ready | input | 1 | Write beat consumed |
| wr_addr | output | REG_W | Destination register of the beat |
| wr_lane_en | output | LANES | Per-lane write enable |
| wr_data | output | LANES*64 | Per-lane widened data |
| done | output | 1 | Command finished pulse |

## Verification
The assertions assume that an accepted `in_count` never exceeds MAX_REGS; one check guards this assumption at the input. They also assume that `wr_ready` may drop at any time. The stimulus only offers counts from 0 to MAX_REGS. It drives each command only while `in_ready` is high, and it withholds `wr_ready` over several cycles of one command so that the hold rule is exercised. Element words carry unrelated bits above the type width, which shows that those bits are ignored.

// File: rtl/lwf_pkg.sv
package lwf_pkg;

  typedef enum logic [3:0] {
    MT_U8  = 4'd0, MT_U16 = 4'd1, MT_U32 = 4'd2, MT_U64 = 4'd3,
    MT_S8  = 4'd4, MT_S16 = 4'd5, MT_S32 = 4'd6, MT_S64 = 4'd7,
    MT_F16 = 4'd8, MT_F32 = 4'd9, MT_F64 = 4'd10
  } mtype_e;

  typedef enum logic [1:0] {
    OP_LOAD = 2'd0, OP_ATOM_RET = 2'd1, OP_STORE = 2'd2, OP_ATOM_NORET = 2'd3
  } op_e;

  function automatic logic op_writes(logic [1:0] op);
    return (op == OP_LOAD) || (op == OP_ATOM_RET);
  endfunction

  // exact half -> single widening
  function automatic logic [31:0] half_to_single(logic [15:0] h);
    logic [4:0]  e;
    logic [9:0]  m;
    logic [22:0] fr;
    int          p;
    logic [31:0] r;
    e = h[14:10];
    m = h[9:0];
    p = 0;
    r = {h[15], 31'b0};
    if (e == 5'd0) begin
      if (m != 10'd0) begin
        for (int b = 0; b < 10; b++) if (m[b]) p = b;
        fr = {13'b0, m} << (23 - p);
        r  = {h[15], 8'(p + 103), fr};
      end
    end else if (e == 5'h1f) begin
      r = {h[15], 8'hff, m, 13'b0};
    end else begin
      r = {h[15], {3'b0, e} + 8'd112, m, 13'b0};
    end
    return r;
  endfunction

  // exact single -> double widening
  function automatic logic [63:0] single_to_double(logic [31:0] s);
    logic [7:0]  e;
    logic [22:0] m;
    logic [51:0] fr;
    int          p;
    logic [63:0] r;
    e = s[30:23];
    m = s[22:0];
    p = 0;
    r = {s[31], 63'b0};
    if (e == 8'd0) begin
      if (m != 23'd0) begin
        for (int b = 0; b < 23; b++) if (m[b]) p = b;
        fr = {29'b0, m} << (52 - p);
        r  = {s[31], 11'(p + 874), fr};
      end
    end else if (e == 8'hff) begin
      r = {s[31], 11'h7ff, m, 29'b0};
    end else begin
      r = {s[31], {3'b0, e} + 11'd896, m, 29'b0};
    end
    return r;
  endfunction

endpackage

// File: rtl/lwf_widen.sv
module lwf_widen
  import lwf_pkg::*;
(
  input  logic [63:0] raw,
  input  logic [3:0]  mtype,
  input  logic        dst64,
  output logic [63:0] val
);
  logic [63:0] wide;

  always_comb begin
    case (mtype)
      MT_U8:  wide = {56'b0, raw[7:0]};
      MT_U16: wide = {48'b0, raw[15:0]};
      MT_U32: wide = {32'b0, raw[31:0]};
      MT_U64: wide = raw;
      MT_S8:  wide = {{56{raw[7]}}, raw[7:0]};
      MT_S16: wide = {{48{raw[15]}}, raw[15:0]};
      MT_S32: wide = {{32{raw[31]}}, raw[31:0]};
      MT_S64: wide = raw;
      MT_F16: wide = dst64 ? single_to_double(half_to_single(raw[15:0]))
                           : {32'b0, half_to_single(raw[15:0])};
      MT_F32: wide = dst64 ? single_to_double(raw[31:0]) : {32'b0, raw[31:0]};
      MT_F64: wide = raw;
      default: wide = 64'b0;
    endcase
    val = dst64 ? wide : {32'b0, wide[31:0]};
  end
endmodule

// File: rtl/lwf_seq.sv
module lwf_seq
  import lwf_pkg::*;
#(
  parameter int MAX_REGS   = 4,
  parameter int DIRECT_MAX = 2,
  parameter int REG_W      = 8,
  localparam int CNT_W  = $clog2(MAX_REGS + 1),
  localparam int IDX_W  = (MAX_REGS > 1) ? $clog2(MAX_REGS) : 1,
  localparam int LIST_W = MAX_REGS * REG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [1:0]        start_op,
  input  logic [CNT_W-1:0]  start_cnt,
  input  logic [REG_W-1:0]  start_base,
  input  logic [LIST_W-1:0] start_list,
  input  logic              wr_ready,
  output logic              busy,
  output logic [IDX_W-1:0]  reg_idx,
  output logic [REG_W-1:0]  wr_addr,
  output logic              done
);
  logic              busy_q, done_q;
  logic [IDX_W-1:0]  idx_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [REG_W-1:0]  base_q;
  logic [LIST_W-1:0] list_q;
  logic              last;

  assign last = (CNT_W'(idx_q) + CNT_W'(1)) == cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      idx_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (start) begin
        idx_q <= '0;
        if (op_writes(start_op) && start_cnt != '0) busy_q <= 1'b1;
        else done_q <= 1'b1;
      end else if (busy_q && wr_ready) begin
        if (last) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          idx_q <= idx_q + IDX_W'(1);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (start) begin
      cnt_q  <= start_cnt;
      base_q <= start_base;
      list_q <= start_list;
    end
  end

  assign busy    = busy_q;
  assign done    = done_q;
  assign reg_idx = idx_q;
  assign wr_addr = (cnt_q > CNT_W'(DIRECT_MAX)) ? list_q[idx_q*REG_W +: REG_W]
                                                : base_q + REG_W'(idx_q);

  // R2: a command without return data yields only a done pulse
  a_r2_no_data_beats: assert property (@(posedge clk) disable iff (!rst_n)
    start && !op_writes(start_op) |=> !busy && done);

  // R9: done follows the last handshake, and no beat remains
  a_r9_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    busy && wr_ready && last |=> done && !busy);

  // R3: the beat index stays below the accepted count
  a_r3_idx_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> CNT_W'(idx_q) < cnt_q);
endmodule

// File: rtl/lane_load_writeback.sv
module lane_load_writeback
  import lwf_pkg::*;
#(
  parameter int LANES      = 64,
  parameter int MAX_REGS   = 4,
  parameter int DIRECT_MAX = 2,
  parameter int REG_W      = 8,
  localparam int ELEMS  = LANES * MAX_REGS,
  localparam int DATA_W = ELEMS * 64,
  localparam int CNT_W  = $clog2(MAX_REGS + 1),
  localparam int IDX_W  = (MAX_REGS > 1) ? $clog2(MAX_REGS) : 1,
  localparam int EIDX_W = $clog2(ELEMS),
  localparam int LIST_W = MAX_REGS * REG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [1:0]        in_op,
  input  logic [3:0]        in_mtype,
  input  logic              in_dst64,
  input  logic [CNT_W-1:0]  in_count,
  input  logic [REG_W-1:0]  in_base,
  input  logic [LIST_W-1:0] in_list,
  input  logic [LANES-1:0]  in_mask,
  input  logic [DATA_W-1:0] in_data,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [REG_W-1:0]  wr_addr,
  output logic [LANES-1:0]  wr_lane_en,
  output logic [LANES*64-1:0] wr_data,
  output logic              done
);
  logic             accept, busy;
  logic [IDX_W-1:0] reg_idx;
  logic [63:0]      elem_q [ELEMS];
  logic [LANES-1:0] mask_q;
  logic [3:0]       mtype_q;
  logic             dst64_q;

  assign in_ready = !busy;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (accept) begin
      mask_q  <= in_mask;
      mtype_q <= in_mtype;
      dst64_q <= in_dst64;
      for (int e = 0; e < ELEMS; e++) elem_q[e] <= in_data[e*64 +: 64];
    end
  end

  lwf_seq #(
    .MAX_REGS(MAX_REGS), .DIRECT_MAX(DIRECT_MAX), .REG_W(REG_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_n),
    .start(accept), .start_op(in_op), .start_cnt(in_count),
    .start_base(in_base), .start_list(in_list),
    .wr_ready(wr_ready), .busy(busy), .reg_idx(reg_idx),
    .wr_addr(wr_addr), .done(done)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [63:0] raw;
    assign raw = elem_q[EIDX_W'(reg_idx) * EIDX_W'(LANES) + EIDX_W'(g)];
    lwf_widen u_widen (
      .raw(raw), .mtype(mtype_q), .dst64(dst64_q), .val(wr_data[g*64 +: 64])
    );
  end

  assign wr_valid   = busy;
  assign wr_lane_en = mask_q;

  // R10: a stalled beat holds its fields
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) &&
                              $stable(wr_data) && $stable(wr_lane_en));

  // R5: the lane enables do not change between beats of one command
  a_r5_mask_steady: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && $past(wr_valid) |-> $stable(wr_lane_en));

  // R1: accepted counts stay within the register budget
  a_r1_count_legal: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |-> in_count <= CNT_W'(MAX_REGS));

  // R6: a 32-bit destination leaves the upper lane half clear
  a_r6_narrow_upper: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !dst64_q |-> wr_data[63:32] == 32'b0);
endmodule

// File: tb/lane_load_writeback_bench.sv
module lane_load_writeback_bench;
  localparam int LANES = 8, MAX_REGS = 4, DIRECT_MAX = 2, REG_W = 8;
  localparam int ELEMS = LANES * MAX_REGS, DATA_W = ELEMS * 64;
  localparam int CNT_W = $clog2(MAX_REGS + 1), LIST_W = MAX_REGS * REG_W;

  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic in_valid = 1'b0, in_ready, in_dst64 = 1'b0, wr_valid, wr_ready = 1'b1, done;
  logic [1:0] in_op = '0;
  logic [3:0] in_mtype = '0;
  logic [CNT_W-1:0] in_count = '0;
  logic [REG_W-1:0] in_base = '0, wr_addr;
  logic [LIST_W-1:0] in_list = '0;
  logic [LANES-1:0] in_mask = '0, wr_lane_en;
  logic [DATA_W-1:0] in_data = '0;
  logic [LANES*64-1:0] wr_data;

  lane_load_writeback #(.LANES(LANES), .MAX_REGS(MAX_REGS), .DIRECT_MAX(DIRECT_MAX),
    .REG_W(REG_W)) u_lane_load_writeback (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_op(in_op),
    .in_mtype(in_mtype), .in_dst64(in_dst64), .in_count(in_count), .in_base(in_base),
    .in_list(in_list), .in_mask(in_mask), .in_data(in_data), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_lane_en(wr_lane_en), .wr_data(wr_data),
    .done(done));

  // {dst64, type code, element, expected lane value}
  localparam int NV = 28;
  localparam logic [132:0] VEC [NV] = '{
    {1'b0, 4'd0, 64'hDEADBEEF_CAFE1281, 64'h00000000_00000081},  // R6
    {1'b0, 4'd4, 64'hDEADBEEF_CAFE1281, 64'h00000000_FFFFFF81},  // R6
    {1'b1, 4'd4, 64'hDEADBEEF_CAFE1281, 64'hFFFFFFFF_FFFFFF81},  // R6
    {1'b0, 4'd1, 64'hDEADBEEF_CAFE9281, 64'h00000000_00009281},  // R6
    {1'b1, 4'd5, 64'hDEADBEEF_CAFE9281, 64'hFFFFFFFF_FFFF9281},  // R6
    {1'b1, 4'd2, 64'hDEADBEEF_80000001, 64'h00000000_80000001},  // R6
    {1'b1, 4'd6, 64'hDEADBEEF_80000001, 64'hFFFFFFFF_80000001},  // R6
    {1'b0, 4'd6, 64'hDEADBEEF_80000001, 64'h00000000_80000001},  // R6
    {1'b0, 4'd3, 64'h12345678_9ABCDEF0, 64'h00000000_9ABCDEF0},  // R7
    {1'b1, 4'd7, 64'h12345678_9ABCDEF0, 64'h12345678_9ABCDEF0},  // R6
    {1'b1, 4'd3, 64'hFFFF0000_11112222, 64'hFFFF0000_11112222},  // R6
    {1'b0, 4'd8, 64'hDEADBEEF_12343C00, 64'h00000000_3F800000},  // R8
    {1'b0, 4'd8, 64'hDEADBEEF_12340001, 64'h00000000_33800000},  // R8
    {1'b0, 4'd8, 64'hDEADBEEF_12347C00, 64'h00000000_7F800000},  // R8
    {1'b0, 4'd8, 64'hDEADBEEF_1234FE00, 64'h00000000_FFC00000},  // R8
    {1'b0, 4'd8, 64'hDEADBEEF_12348000, 64'h00000000_80000000},  // R8
    {1'b0, 4'd8, 64'hDEADBEEF_123403FF, 64'h00000000_387FC000},  // R8
    {1'b1, 4'd9, 64'hDEADBEEF_3F800000, 64'h3FF00000_00000000},  // R8
    {1'b1, 4'd9, 64'hDEADBEEF_00000001, 64'h36A00000_00000000},  // R8
    {1'b1, 4'd9, 64'hDEADBEEF_FF800000, 64'hFFF00000_00000000},  // R8
    {1'b1, 4'd9, 64'hDEADBEEF_7FC00001, 64'h7FF80000_20000000},  // R8
    {1'b1, 4'd8, 64'hDEADBEEF_12343C00, 64'h3FF00000_00000000},  // R8
    {1'b1, 4'd8, 64'hDEADBEEF_12340001, 64'h3E700000_00000000},  // R8
    {1'b0, 4'd9, 64'hDEADBEEF_40490FDB, 64'h00000000_40490FDB},  // R8
    {1'b1, 4'd10, 64'h400921FB_54442D18, 64'h400921FB_54442D18}, // R8
    {1'b1, 4'd12, 64'h400921FB_54442D18, 64'h00000000_00000000}, // R8
    {1'b0, 4'd10, 64'h400921FB_54442D18, 64'h00000000_54442D18}, // R7
    {1'b1, 4'd9, 64'hDEADBEEF_40490FDB, 64'h400921FB_60000000}   // R8
  };

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  logic [REG_W-1:0]    b_addr [8];
  logic [LANES-1:0]    b_en   [8];
  logic [LANES*64-1:0] b_data [8];
  int  nb;
  bit  first_valid, got_done;

  task automatic send(input logic [1:0] op, input logic [3:0] mt, input logic d64,
                      input int cnt, input logic [REG_W-1:0] base,
                      input logic [LIST_W-1:0] lst, input logic [LANES-1:0] msk);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1; in_op = op; in_mtype = mt; in_dst64 = d64;
    in_count = CNT_W'(cnt); in_base = base; in_list = lst; in_mask = msk;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic collect();
    nb = 0; got_done = 0; first_valid = wr_valid;
    for (int c = 0; c < 20 && !got_done; c++) begin
      if (done) got_done = 1;
      else begin
        if (wr_valid && wr_ready && nb < 8) begin
          b_addr[nb] = wr_addr; b_en[nb] = wr_lane_en; b_data[nb] = wr_data; nb++;
        end
        @(negedge clk);
      end
    end
  endtask

  initial begin
    logic [REG_W-1:0] hold_addr;
    logic [LANES*64-1:0] hold_data;
    repeat (3) @(negedge clk);
    chk("R11 in_ready", 64'(in_ready), 64'd1);
    chk("R11 wr_valid", 64'(wr_valid), 64'd0);
    chk("R11 done", 64'(done), 64'd0);
    rst_n = 1'b1;

    // conversion table, one register, all lanes
    for (int v = 0; v < NV; v++) begin
      for (int e = 0; e < ELEMS; e++) in_data[e*64 +: 64] = VEC[v][127:64];
      send(2'd0, VEC[v][131:128], VEC[v][132], 1, 8'd5, '0, '1);
      collect();
      chk($sformatf("R9 vector %0d beat count", v), 64'(nb), 64'd1);
      for (int i = 0; i < LANES; i++)
        chk($sformatf("R6-R8 vector %0d lane %0d", v, i), b_data[0][i*64 +: 64], VEC[v][63:0]);
    end

    // contiguous addressing, partial mask
    for (int e = 0; e < ELEMS; e++) in_data[e*64 +: 64] = {32'hBAD0BAD0, 32'h1000 + 32'(e)};
    send(2'd0, 4'd2, 1'b1, 2, 8'd10, '1, 8'hA6);
    collect();
    chk("R9 first beat after accept", 64'(first_valid), 64'd1);
    chk("R9 beats", 64'(nb), 64'd2);
    chk("R9 done", 64'(got_done), 64'd1);
    for (int k = 0; k < 2; k++) begin
      chk("R3 contiguous addr", 64'(b_addr[k]), 64'(10 + k));
      chk("R5 lane enables", 64'(b_en[k]), 64'hA6);
      for (int i = 0; i < LANES; i++)
        chk("R4 placement", b_data[k][i*64 +: 64], 64'h1000 + 64'(k*LANES + i));
    end

    // listed addressing, count 3 and count 4
    send(2'd0, 4'd2, 1'b0, 3, 8'd10, {8'd99, 8'd22, 8'd7, 8'd40}, 8'h01);
    collect();
    chk("R3 listed beats", 64'(nb), 64'd3);
    chk("R3 list entry 0", 64'(b_addr[0]), 64'd40);
    chk("R3 list entry 1", 64'(b_addr[1]), 64'd7);
    chk("R3 list entry 2", 64'(b_addr[2]), 64'd22);
    chk("R5 single lane", 64'(b_en[2]), 64'h01);
    chk("R4 reg 2 lane 7", b_data[2][7*64 +: 64], 64'h1000 + 64'(2*LANES + 7));
    send(2'd1, 4'd2, 1'b0, 4, 8'd10, {8'd99, 8'd22, 8'd7, 8'd40}, 8'hFF);
    collect();
    chk("R2 atomic return beats", 64'(nb), 64'd4);
    chk("R3 list entry 3", 64'(b_addr[3]), 64'd99);

    // operations without write data
    send(2'd2, 4'd2, 1'b0, 2, 8'd10, '0, '1);
    collect();
    chk("R2 store beats", 64'(nb), 64'd0);
    chk("R2 store done timing", 64'(first_valid == 0 && got_done), 64'd1);
    send(2'd3, 4'd2, 1'b0, 1, 8'd10, '0, '1);
    collect();
    chk("R2 plain atomic beats", 64'(nb), 64'd0);
    chk("R2 plain atomic done", 64'(got_done), 64'd1);

    // back-pressure and capture of inputs
    wr_ready = 1'b0;
    send(2'd0, 4'd2, 1'b0, 2, 8'd30, '0, 8'h3C);
    hold_addr = wr_addr; hold_data = wr_data;
    in_base = 8'd77;
    for (int e = 0; e < ELEMS; e++) in_data[e*64 +: 64] = 64'h0;
    chk("R1 busy blocks input", 64'(in_ready), 64'd0);
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      chk("R10 valid held", 64'(wr_valid), 64'd1);
      chk("R10 addr held", 64'(wr_addr), 64'(hold_addr));
      chk("R10 data held", wr_data[63:0], hold_data[63:0]);
    end
    wr_ready = 1'b1;
    collect();
    chk("R1 captured beats", 64'(nb), 64'd2);
    chk("R1 captured base", 64'(b_addr[1]), 64'd31);
    chk("R1 captured data", b_data[1][0 +: 64], 64'h1000 + 64'(LANES));
    chk("R1 ready after done", 64'(in_ready), 64'd1);

    finish_run();
  end
endmodule